// File: doc/BRIEF.md
# Dual-Half Cipher Feedback Stream Sequencer

This block runs cipher feedback (CFB) mode with a 64-bit block cipher over a 128-bit feedback register. The register is handled as two separate 64-bit halves. Each half is encrypted in turn by an external block cipher, and the resulting keystream is applied to two 32-bit stream words. Data therefore moves in groups of four words. Each group makes two cipher calls: first the upper half, then the lower half.

Software loads four feedback words, a direction bit and a group count with a single load pulse. Source words arrive on a valid/ready stream, and result words leave on another valid/ready stream. Both directions use only the forward cipher. When encrypting, the result word is fed back. When decrypting, the incoming source word is fed back. The block waits on the output consumer, so it never takes a source word whose result cannot be presented in the same cycle. A done level marks the end of the last group.

Top module: `cfb_dual_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `res_valid_o`, `src_ready_o` and `blk_start_o` are all 0.
- R2: The cipher input for the first half is {word 0, word 1} and for the second half is {word 2, word 3}. The lower-index word sits in bits 63:32. Word k of `cfg_iv_i` is bits [127-32k -: 32]. `blk_in_o` stays stable while a cipher call is outstanding.
- R3: Each group makes exactly two cipher calls, first half then second half. The second-half call starts only after both first-half words have been exchanged, so at every start the number of accepted results equals twice the number of earlier starts.
- R4: When encrypting (`cfg_decrypt_i`=0), each result is the keystream word XOR the source word. The first word of a half uses keystream bits 63:32. The result replaces the matching feedback word.
- R5: When decrypting (`cfg_decrypt_i`=1), the result is computed the same way, using the forward cipher. The source word replaces the matching feedback word, so decrypting a ciphertext with the same feedback words recovers the plaintext.
- R6: A load with a group count of 0 raises `done_o` on the next cycle and starts no cipher call.
- R7: `done_o` rises the cycle after the last result of the last group is accepted. It stays high with `busy_o` low until the next load.
- R8: `src_ready_o` is high only while `res_ready_i` is high, and `res_valid_o` only while `src_valid_i` is high. A source word is consumed exactly when its result is accepted.
- R9: `blk_start_o` is a one-cycle pulse. No new start is issued until `blk_done_i` returns the previous call.
- R10: A load pulse while `busy_o` is high is ignored. The running sequence continues with its original feedback words and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | Load pulse for feedback words, direction and count |
| cfg_decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| cfg_groups_i | input | GROUP_W | Number of four-word groups |
| cfg_iv_i | input | 128 | Initial feedback words, word 0 in the top bits |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Source word accepted |
| src_data_i | input | 32 | Source word |
| res_valid_o | output | 1 | Result word valid |
| res_ready_i | input | 1 | Consumer ready for result |
| res_data_o | output | 32 | Result word |
| blk_start_o | output | 1 | Start pulse to the block cipher |
| blk_in_o | output | 64 | Block presented to the cipher |
| blk_out_i | input | 64 | Encrypted block from the cipher |
| blk_done_i | input | 1 | Cipher result valid |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All groups finished |

## Verification
The result path is combinational: a result word is due in the same cycle its source word is presented, once the keystream is held. The bench therefore samples every handshake on the falling edge and drives inputs one time unit after the rising edge. A cipher start appears one cycle after the load or after the last handshake of the previous half. `done_o` appears one cycle after the final handshake, or one cycle after a zero-count load. The bench's reference model predicts each cipher input block and each result word in queues. It pops and compares them at the exact cycle of each start and each result handshake, under steady and irregular valid/ready pacing.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    localparam int WORD_W = 32;
    localparam int BLK_W  = 2 * WORD_W;
    localparam int NWORDS = 4;
    localparam int IDX_W  = $clog2(NWORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALL,
        ST_WAIT,
        ST_W0,
        ST_W1,
        ST_FIN
    } seq_st_e;

    // Keystream word for position lo within a half: 0 -> upper bits
    function automatic word_t ks_pick(input blk_t ks, input logic lo);
        return lo ? ks[WORD_W-1:0] : ks[BLK_W-1:WORD_W];
    endfunction
endpackage

// File: rtl/cfb_fsm.sv
module cfb_fsm
    import cfb_pkg::*;
#(
    parameter int GROUP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load_i,
    input  logic [GROUP_W-1:0] cfg_groups_i,
    input  logic               src_valid_i,
    input  logic               res_ready_i,
    input  logic               blk_done_i,
    output logic               load_acc_o,
    output logic               xfer_o,
    output logic               word_phase_o,
    output logic               word_sel_o,
    output logic               half_o,
    output logic               ks_cap_o,
    output logic               wait_o,
    output logic               blk_start_o,
    output logic               busy_o,
    output logic               done_o
);
    seq_st_e            st_q;
    logic               half_q;
    logic [GROUP_W-1:0] left_q;

    assign busy_o       = (st_q != ST_IDLE) && (st_q != ST_FIN);
    assign done_o       = (st_q == ST_FIN);
    assign load_acc_o   = cfg_load_i && !busy_o;
    assign word_phase_o = (st_q == ST_W0) || (st_q == ST_W1);
    assign word_sel_o   = (st_q == ST_W1);
    assign xfer_o       = word_phase_o && src_valid_i && res_ready_i;
    assign blk_start_o  = (st_q == ST_CALL);
    assign wait_o       = (st_q == ST_WAIT);
    assign ks_cap_o     = wait_o && blk_done_i;
    assign half_o       = half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            half_q <= 1'b0;
            left_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_FIN: begin
                    if (cfg_load_i) begin
                        left_q <= cfg_groups_i;
                        half_q <= 1'b0;
                        st_q   <= (cfg_groups_i == '0) ? ST_FIN : ST_CALL;
                    end
                end
                ST_CALL: st_q <= ST_WAIT;
                ST_WAIT: if (blk_done_i) st_q <= ST_W0;
                ST_W0:   if (xfer_o) st_q <= ST_W1;
                ST_W1: begin
                    if (xfer_o) begin
                        if (!half_q) begin
                            half_q <= 1'b1;
                            st_q   <= ST_CALL;
                        end else begin
                            half_q <= 1'b0;
                            left_q <= left_q - 1'b1;
                            st_q   <= (left_q == GROUP_W'(1)) ? ST_FIN : ST_CALL;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blk_start_o |=> !blk_start_o);
    // R9
    start_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_o && !blk_done_i) |=> !blk_start_o);
    // R6
    zero_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (load_acc_o && cfg_groups_i == '0) |=> done_o);
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cfg_load_i) |=> (done_o && !busy_o));
endmodule

// File: rtl/cfb_regs.sv
module cfb_regs
    import cfb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic [NWORDS*WORD_W-1:0] cfg_iv_i,
    input  logic                     cfg_decrypt_i,
    input  logic                     half_i,
    input  logic                     word_sel_i,
    input  logic                     xfer_i,
    input  logic                     ks_cap_i,
    input  blk_t                     blk_out_i,
    input  word_t                    src_data_i,
    output blk_t                     blk_in_o,
    output word_t                    res_data_o
);
    word_t            iv_q [NWORDS];
    blk_t             ks_q;
    logic             dec_q;
    logic [IDX_W-1:0] wr_idx;
    word_t            fb_word;

    assign wr_idx     = {half_i, word_sel_i};
    assign res_data_o = ks_pick(ks_q, word_sel_i) ^ src_data_i;
    assign fb_word    = dec_q ? src_data_i : res_data_o;
    assign blk_in_o   = {iv_q[{half_i, 1'b0}], iv_q[{half_i, 1'b1}]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ks_q  <= '0;
            dec_q <= 1'b0;
        end else begin
            if (load_i)   dec_q <= cfg_decrypt_i;
            if (ks_cap_i) ks_q  <= blk_out_i;
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_iv
        always_ff @(posedge clk) begin
            if (rst)
                iv_q[g] <= '0;
            else if (load_i)
                iv_q[g] <= cfg_iv_i[(NWORDS-1-g)*WORD_W +: WORD_W];
            else if (xfer_i && wr_idx == IDX_W'(g))
                iv_q[g] <= fb_word;
        end
    end

    // R4
    enc_fb_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !dec_q) |=> iv_q[$past(wr_idx)] == $past(res_data_o));
    // R5
    dec_fb_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && dec_q) |=> iv_q[$past(wr_idx)] == $past(src_data_i));
endmodule

// File: rtl/cfb_dual_seq.sv
module cfb_dual_seq
    import cfb_pkg::*;
#(
    parameter int GROUP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_load_i,
    input  logic                     cfg_decrypt_i,
    input  logic [GROUP_W-1:0]       cfg_groups_i,
    input  logic [NWORDS*WORD_W-1:0] cfg_iv_i,
    input  logic                     src_valid_i,
    output logic                     src_ready_o,
    input  logic [WORD_W-1:0]        src_data_i,
    output logic                     res_valid_o,
    input  logic                     res_ready_i,
    output logic [WORD_W-1:0]        res_data_o,
    output logic                     blk_start_o,
    output logic [BLK_W-1:0]         blk_in_o,
    input  logic [BLK_W-1:0]         blk_out_i,
    input  logic                     blk_done_i,
    output logic                     busy_o,
    output logic                     done_o
);
    logic load_acc, xfer, word_phase, word_sel, half, ks_cap, waiting;

    cfb_fsm #(.GROUP_W(GROUP_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cfg_load_i   (cfg_load_i),
        .cfg_groups_i (cfg_groups_i),
        .src_valid_i  (src_valid_i),
        .res_ready_i  (res_ready_i),
        .blk_done_i   (blk_done_i),
        .load_acc_o   (load_acc),
        .xfer_o       (xfer),
        .word_phase_o (word_phase),
        .word_sel_o   (word_sel),
        .half_o       (half),
        .ks_cap_o     (ks_cap),
        .wait_o       (waiting),
        .blk_start_o  (blk_start_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    cfb_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .load_i        (load_acc),
        .cfg_iv_i      (cfg_iv_i),
        .cfg_decrypt_i (cfg_decrypt_i),
        .half_i        (half),
        .word_sel_i    (word_sel),
        .xfer_i        (xfer),
        .ks_cap_i      (ks_cap),
        .blk_out_i     (blk_out_i),
        .src_data_i    (src_data_i),
        .blk_in_o      (blk_in_o),
        .res_data_o    (res_data_o)
    );

    assign src_ready_o = word_phase && res_ready_i;
    assign res_valid_o = word_phase && src_valid_i;

    // R2
    blk_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (waiting && !blk_done_i) |=> $stable(blk_in_o));
    // R8
    pair_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (src_valid_i && src_ready_o) |-> (res_valid_o && res_ready_i));
    // R10
    busy_load_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cfg_load_i && !done_o) |=> !done_o || $past(xfer));
endmodule

// File: tb/sim_cfb_dual_seq.sv
module sim_cfb_dual_seq;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_load = 1'b0, cfg_decrypt = 1'b0;
    logic [15:0]  cfg_groups = '0;
    logic [127:0] cfg_iv = '0;
    logic         src_valid = 1'b0, src_ready;
    logic [31:0]  src_data = '0;
    logic         res_valid, res_ready = 1'b0;
    logic [31:0]  res_data;
    logic         blk_start, blk_done = 1'b0;
    logic [63:0]  blk_in, blk_out = '0;
    logic         busy, done;

    int total = 0, bad = 0;
    int cyc = 0;
    int ready_mode = 0;
    int n_start = 0, n_res = 0;
    logic [31:0] exp_res[$];
    logic [63:0] exp_blk[$];
    logic [31:0] din[$];
    logic [31:0] got[$];
    logic        cur_dec = 1'b0;
    logic        prev_start = 1'b0;

    always #2 clk = ~clk;

    cfb_dual_seq u0 (
        .clk(clk), .rst(rst), .cfg_load_i(cfg_load), .cfg_decrypt_i(cfg_decrypt),
        .cfg_groups_i(cfg_groups), .cfg_iv_i(cfg_iv), .src_valid_i(src_valid),
        .src_ready_o(src_ready), .src_data_i(src_data), .res_valid_o(res_valid),
        .res_ready_i(res_ready), .res_data_o(res_data), .blk_start_o(blk_start),
        .blk_in_o(blk_in), .blk_out_i(blk_out), .blk_done_i(blk_done),
        .busy_o(busy), .done_o(done)
    );

    function automatic logic [63:0] stub_f(input logic [63:0] b);
        return {b[31:0] ^ 32'h9E37_79B9, {b[62:32], b[63]} + 32'h1234_5678};
    endfunction

    // stub cipher with fixed latency
    logic [63:0] cap = '0;
    int          cnt = 0;
    logic        s_busy = 1'b0;
    always @(posedge clk) begin
        blk_done <= 1'b0;
        if (blk_start) begin
            cap <= blk_in; cnt <= LAT; s_busy <= 1'b1;
        end else if (s_busy) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                blk_done <= 1'b1; blk_out <= stub_f(cap); s_busy <= 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        res_ready <= (ready_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // cycle monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (blk_start) begin
                // R3: second-half call only after both first-half words
                check(n_res == 2 * n_start, "R3", n_res, 2 * n_start);
                // R9: single-cycle pulse, no start while cipher busy
                check(!prev_start && !s_busy, "R9", {prev_start, s_busy}, 0);
                if (exp_blk.size() == 0) check(0, "R2", blk_in, 0);
                else begin
                    logic [63:0] e;
                    e = exp_blk.pop_front();
                    check(blk_in == e, "R2", blk_in, e);
                end
                n_start++;
            end
            if (src_ready || res_valid) begin
                // R8
                check((!src_ready || res_ready) && (!res_valid || src_valid),
                      "R8", {src_ready, res_ready, res_valid, src_valid}, 0);
            end
            if (res_valid && res_ready) begin
                if (exp_res.size() == 0) check(0, cur_dec ? "R5" : "R4", res_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_res.pop_front();
                    check(res_data == e, cur_dec ? "R5" : "R4", res_data, e);
                end
                got.push_back(res_data);
                n_res++;
            end
            prev_start = blk_start;
        end
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send_words(input int n, input bit gappy);
        int i = 0;
        while (i < n) begin
            @(posedge clk); #1;
            if (gappy && ($urandom % 4 == 0)) src_valid = 1'b0;
            else begin src_valid = 1'b1; src_data = din[i]; end
            @(negedge clk);
            if (src_valid && src_ready) i++;
        end
        @(posedge clk); #1;
        src_valid = 1'b0;
    endtask

    task automatic run_case(input logic [127:0] iv, input bit dec, input int groups,
                            input bit gappy, input bit poke);
        logic [31:0] miv[4];
        exp_res.delete(); exp_blk.delete(); got.delete();
        n_start = 0; n_res = 0; cur_dec = dec;
        for (int k = 0; k < 4; k++) miv[k] = iv[127-32*k -: 32];
        for (int g = 0; g < groups; g++)
            for (int h = 0; h < 2; h++) begin
                logic [63:0] ks;
                exp_blk.push_back({miv[2*h], miv[2*h+1]});
                ks = stub_f({miv[2*h], miv[2*h+1]});
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] s, o;
                    s = din[4*g + 2*h + w];
                    o = (w == 0 ? ks[63:32] : ks[31:0]) ^ s;
                    exp_res.push_back(o);
                    miv[2*h+w] = dec ? s : o;
                end
            end
        @(posedge clk); #1;
        cfg_iv = iv; cfg_decrypt = dec; cfg_groups = 16'(groups); cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        if (poke) begin
            @(posedge clk); #1;
            cfg_load = 1'b1; cfg_iv = ~iv; cfg_groups = 16'd0; cfg_decrypt = ~dec;
            @(negedge clk);
            // R10: load while busy leaves sequence running
            check(busy && !done, "R10", {busy, done}, 2'b10);
            @(posedge clk); #1;
            cfg_load = 1'b0;
        end
        send_words(groups * 4, gappy);
        for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
        // R7
        check(done && !busy, "R7", {done, busy}, 2'b10);
        check(exp_res.size() == 0 && exp_blk.size() == 0, "R3",
              exp_res.size() + exp_blk.size(), 0);
        check(n_start == 2 * groups, "R3", n_start, 2 * groups);
        repeat (3) @(negedge clk);
        // R7: done held
        check(done && !busy, "R7", {done, busy}, 2'b10);
    endtask

    initial begin
        logic [31:0] pt[$];
        logic [31:0] ct[$];
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy && !done && !res_valid && !src_ready && !blk_start, "R1",
              {busy, done, res_valid, src_ready, blk_start}, 0);

        for (int i = 0; i < 12; i++) din.push_back(32'h1000_0001 * (i + 3) ^ 32'hC3A5_5A3C);
        pt = din;
        ready_mode = 0;
        run_case(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0, 3, 1'b0, 1'b0);
        ct = got;
        // R5: decrypt ciphertext with same feedback words, irregular pacing
        din = ct;
        ready_mode = 1;
        run_case(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, 3, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) check(got[i] == pt[i], "R5", got[i], pt[i]);

        // R4 with backpressure, gaps and an ignored load (R10)
        din.delete();
        for (int i = 0; i < 8; i++) din.push_back(32'hDEAD_0000 + 32'(i * 7919));
        run_case(128'hAAAA_5555_0F0F_F0F0_1234_8765_FFFF_0000, 1'b0, 2, 1'b1, 1'b1);

        // R6: zero groups
        ready_mode = 0;
        n_start = 0;
        @(posedge clk); #1;
        cfg_groups = 16'd0; cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        @(negedge clk);
        check(done && !busy, "R6", {done, busy}, 2'b10);
        repeat (4) @(negedge clk);
        check(n_start == 0, "R6", n_start, 0);

        // single group, decrypt, steady pacing
        din.delete();
        for (int i = 0; i < 4; i++) din.push_back(32'h5A5A_0000 | 32'(i));
        run_case(128'h0, 1'b1, 1, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule